// File: doc/BRIEF.md
# Field-Sequenced BCD Digit Register ALU

This block is the register-to-register arithmetic core of a decimal calculator processor. Its working registers are rows of 4-bit BCD digits held in a small single-port RAM. It takes in one pre-expanded control word per instruction. The word names an operation code, a source register, a destination register and an inclusive range of digit positions. No opcode lookup stands between the control word and the datapath.

For each digit in the range, from the lowest position upward, the block does three things. It reads the source digit into a latch, reads the destination digit into a second latch, then writes the result digit back to the destination. An exchange adds a fourth cycle that writes the old destination digit into the source. Add and subtract pass a decimal carry or borrow from digit to digit, and the carry out of the last digit is kept as a flag.

Either bound of the range can be taken from an external pointer value instead of the control word. Multi-step operations such as stack moves are built by issuing a series of these instructions one after another. Every RAM write is shown on a write-trace output, so the surrounding logic can follow the results.

Top module: `nib_field_alu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, busy, done, carry and wr_valid are all 0.
- R2: An instruction writes the destination digits in ascending order, one write per digit from the low bound to the high bound inclusive. No other position is written. Each write is shown on wr_valid / wr_reg / wr_pos / wr_digit in the cycle before the RAM takes it. Every digit step has 3 cycles (read source, read destination, write), or 4 for an exchange.
- R3: If the low bound is greater than the high bound, the field is the single digit at the low bound. A bound greater than DIGITS-1 is clamped to DIGITS-1.
- R4: When start_from_ptr is 1, ptr replaces fstart as the low bound. When end_from_ptr is 1, ptr replaces fend as the high bound.
- R5: op 0 (copy) writes the source digit. op 3 (clear) writes 0. op 5 (load) writes imm. Op codes 6 and 7 act as copy. Each of these leaves carry at 0 when done.
- R6: op 1 (add) writes (dst + src + c) as a decimal digit. A digit sum above 9 is corrected by adding 6 and sets the carry into the next digit. The carry starts at 0, and the carry out of the last digit appears on carry together with done.
- R7: op 2 (subtract) writes (dst - src - b) as a decimal digit. A negative difference is corrected by adding 10 and sets the borrow into the next digit. The borrow out of the last digit appears on carry together with done.
- R8: op 4 (exchange) writes, for each digit, the old source digit into the destination and then, in the next cycle, the old destination digit into the source. carry is 0 when done.
- R9: start is accepted only while busy is 0, and busy is 1 from the next cycle until the instruction ends. A start while busy has no effect. done is a one-cycle pulse, issued with busy at 0, after the last digit has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction strobe, taken only while idle |
| op | input | 3 | Operation code |
| src | input | RW | Source register number |
| dst | input | RW | Destination register number |
| fstart | input | PW | Field low digit from the control word |
| fend | input | PW | Field high digit from the control word |
| start_from_ptr | input | 1 | Take the low bound from ptr |
| end_from_ptr | input | 1 | Take the high bound from ptr |
| ptr | input | PW | Pointer register value |
| imm | input | 4 | Constant digit for load |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| carry | output | 1 | Carry or borrow out of the last digit |
| wr_valid | output | 1 | A RAM write happens at the next edge |
| wr_reg | output | RW | Register being written |
| wr_pos | output | PW | Digit position being written |
| wr_digit | output | 4 | Digit being written |

## Verification
The bench aims at the field edges. It uses a reversed range, which a design that walks the counter from the wrong end or wraps past the top would turn into many writes, and bounds above the top digit, which an unclamped design would write outside the register. It drives carry chains that run through several digits and out of the last one, and it includes a borrow out of the top digit. A design that loses the correction or the carry between steps writes wrong digits, or raises the flag on the wrong instruction. It also tests exchange ordering, pointer-selected bounds, and a start pulse during a busy instruction, which a design without the idle guard would turn into unexpected writes.

// File: rtl/nib_field_alu.sv
`timescale 1ns/1ps
module nib_field_alu #(
  parameter int NREG   = 8,
  parameter int DIGITS = 14,
  localparam int RW = $clog2(NREG),
  localparam int PW = $clog2(DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  input  logic [PW-1:0] fstart,
  input  logic [PW-1:0] fend,
  input  logic          start_from_ptr,
  input  logic          end_from_ptr,
  input  logic [PW-1:0] ptr,
  input  logic [3:0]    imm,
  output logic          busy,
  output logic          done,
  output logic          carry,
  output logic          wr_valid,
  output logic [RW-1:0] wr_reg,
  output logic [PW-1:0] wr_pos,
  output logic [3:0]    wr_digit
);
  localparam int DEPTH = NREG * DIGITS;
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DIGITS - 1);
  localparam logic [2:0] OP_ADD = 3'd1, OP_SUB = 3'd2, OP_CLR = 3'd3,
                         OP_XCH = 3'd4, OP_LOAD = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_WR, S_WR2} st_t;
  st_t st;

  logic [3:0]    mem [DEPTH];
  logic [2:0]    op_q;
  logic [RW-1:0] src_q, dst_q;
  logic [PW-1:0] pos, hi_q;
  logic [3:0]    imm_q, a_q, b_q, res;
  logic          cy_q, cy_n;

  logic [PW-1:0] lo_raw, hi_raw, lo_c, hi_c;
  assign lo_raw = start_from_ptr ? ptr : fstart;
  assign hi_raw = end_from_ptr ? ptr : fend;
  assign lo_c   = (lo_raw > LAST) ? LAST : lo_raw;
  assign hi_c   = (hi_raw > LAST) ? LAST : hi_raw;

  logic [RW-1:0] sel_reg;
  logic [AW-1:0] addr;
  assign sel_reg = (st == S_RDA || st == S_WR2) ? src_q : dst_q;
  assign addr    = AW'(sel_reg) * AW'(DIGITS) + AW'(pos);

  logic [4:0] sum, dif;
  assign sum = {1'b0, b_q} + {1'b0, a_q} + {4'd0, cy_q};
  assign dif = {1'b0, b_q} - {1'b0, a_q} - {4'd0, cy_q};

  always_comb begin
    cy_n = 1'b0;
    case (op_q)
      OP_ADD: begin
        cy_n = sum > 5'd9;
        res  = cy_n ? 4'(sum + 5'd6) : sum[3:0];
      end
      OP_SUB: begin
        cy_n = dif[4];
        res  = cy_n ? 4'(dif + 5'd10) : dif[3:0];
      end
      OP_CLR:  res = 4'd0;
      OP_LOAD: res = imm_q;
      default: res = a_q;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign wr_valid = (st == S_WR) || (st == S_WR2);
  assign wr_reg   = sel_reg;
  assign wr_pos   = pos;
  assign wr_digit = (st == S_WR2) ? b_q : res;

  always_ff @(posedge clk)
    if (wr_valid) mem[addr] <= wr_digit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; carry <= 1'b0; cy_q <= 1'b0;
      op_q <= '0; src_q <= '0; dst_q <= '0; pos <= '0; hi_q <= '0;
      imm_q <= '0; a_q <= '0; b_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= op; src_q <= src; dst_q <= dst; imm_q <= imm;
          pos <= lo_c; hi_q <= (hi_c < lo_c) ? lo_c : hi_c;
          cy_q <= 1'b0; st <= S_RDA;
        end
        S_RDA: begin a_q <= mem[addr]; st <= S_RDB; end
        S_RDB: begin b_q <= mem[addr]; st <= S_WR; end
        S_WR: begin
          cy_q <= cy_n;
          if (op_q == OP_XCH) st <= S_WR2;
          else if (pos == hi_q) begin st <= S_IDLE; done <= 1'b1; carry <= cy_n; end
          else begin pos <= pos + 1'b1; st <= S_RDA; end
        end
        S_WR2: begin
          if (pos == hi_q) begin st <= S_IDLE; done <= 1'b1; carry <= cy_q; end
          else begin pos <= pos + 1'b1; st <= S_RDA; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nib_field_alu_chk #(
  parameter int NREG = 8, parameter int DIGITS = 14,
  localparam int RW = $clog2(NREG), localparam int PW = $clog2(DIGITS)
) (
  input logic clk, input logic rst_n, input logic start, input logic [2:0] op,
  input logic [RW-1:0] src, input logic [RW-1:0] dst,
  input logic [PW-1:0] fstart, input logic [PW-1:0] fend,
  input logic start_from_ptr, input logic end_from_ptr, input logic [PW-1:0] ptr,
  input logic busy, input logic done, input logic carry,
  input logic wr_valid, input logic [RW-1:0] wr_reg, input logic [PW-1:0] wr_pos
);
  localparam logic [PW-1:0] LAST = PW'(DIGITS - 1);
  logic [PW-1:0] lo_k, hi_k, l, h;
  logic [RW-1:0] src_k, dst_k;
  logic xch_k;
  assign l = (start_from_ptr ? ptr : fstart) > LAST ? LAST : (start_from_ptr ? ptr : fstart);
  assign h = (end_from_ptr ? ptr : fend) > LAST ? LAST : (end_from_ptr ? ptr : fend);

  always_ff @(posedge clk)
    if (!rst_n) begin
      lo_k <= '0; hi_k <= '0; src_k <= '0; dst_k <= '0; xch_k <= 1'b0;
    end else if (start && !busy) begin
      lo_k <= l; hi_k <= (h < l) ? l : h;
      src_k <= src; dst_k <= dst; xch_k <= (op == 3'd4);
    end

  p_in_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_pos >= lo_k && wr_pos <= hi_k));
  p_one_write_per_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !xch_k) |=> !wr_valid);
  p_exch_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && xch_k && !$past(wr_valid)) |=> (wr_valid && wr_reg == src_k));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_valid) ##1 !done);
  p_carry_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(carry) |-> done);
endmodule

bind nib_field_alu nib_field_alu_chk #(.NREG(NREG), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src), .dst(dst),
  .fstart(fstart), .fend(fend), .start_from_ptr(start_from_ptr),
  .end_from_ptr(end_from_ptr), .ptr(ptr), .busy(busy), .done(done),
  .carry(carry), .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_pos(wr_pos));

// File: tb/nib_field_alu_test.sv
`timescale 1ns/1ps
module nib_field_alu_test;
  localparam int NREG = 8, DIGITS = 14;
  localparam int RW = $clog2(NREG), PW = $clog2(DIGITS);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, start_from_ptr = 1'b0, end_from_ptr = 1'b0;
  logic [2:0] op = '0;
  logic [RW-1:0] src = '0, dst = '0;
  logic [PW-1:0] fstart = '0, fend = '0, ptr = '0;
  logic [3:0] imm = '0;
  logic busy, done, carry, wr_valid;
  logic [RW-1:0] wr_reg;
  logic [PW-1:0] wr_pos;
  logic [3:0] wr_digit;

  nib_field_alu #(.NREG(NREG), .DIGITS(DIGITS)) uut (.*);

  typedef struct { int r; int p; int d; string tag; } wr_t;
  wr_t exq[$];
  wr_t it;
  int mdl [NREG][DIGITS];
  int checks = 0, errors = 0, nwr = 0, expwr = 0;

  always @(negedge clk) if (rst_n && wr_valid) begin
    nwr++; checks++;
    if (exq.size() == 0) begin
      errors++;
      $display("FAIL R2 unexpected write reg %0d pos %0d digit %0d, expected none",
               wr_reg, wr_pos, wr_digit);
    end else begin
      it = exq.pop_front();
      if (int'(wr_reg) != it.r || int'(wr_pos) != it.p || int'(wr_digit) != it.d) begin
        errors++;
        $display("FAIL %s write got reg %0d pos %0d digit %0d expected reg %0d pos %0d digit %0d",
                 it.tag, wr_reg, wr_pos, wr_digit, it.r, it.p, it.d);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input int o, input int s, input int d, input int fs, input int fe,
                     input bit sp, input bit ep, input int pt, input int im,
                     input string tag, input bit poke = 1'b0);
    int lo, hi, cy, a, b, r, n;
    lo = sp ? pt : fs; hi = ep ? pt : fe;
    if (lo > DIGITS-1) lo = DIGITS-1;
    if (hi > DIGITS-1) hi = DIGITS-1;
    if (hi < lo) hi = lo;
    cy = 0;
    for (int p = lo; p <= hi; p++) begin
      a = mdl[s][p]; b = mdl[d][p];
      case (o)
        1: begin r = b + a + cy; cy = (r > 9); if (cy) r = r - 10; end
        2: begin r = b - a - cy; cy = (r < 0); if (cy) r = r + 10; end
        3: r = 0;
        5: r = im;
        default: r = a;
      endcase
      if (o != 1 && o != 2) cy = 0;
      exq.push_back('{d, p, r, tag}); mdl[d][p] = r; expwr++;
      if (o == 4) begin
        exq.push_back('{s, p, b, tag}); mdl[s][p] = b; expwr++;
      end
    end
    @(negedge clk);
    op = 3'(o); src = RW'(s); dst = RW'(d); fstart = PW'(fs); fend = PW'(fe);
    start_from_ptr = sp; end_from_ptr = ep; ptr = PW'(pt); imm = 4'(im);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy after accept"}, busy, 1);
    if (poke) begin
      @(negedge clk);
      op = 3'd3; dst = RW'(5); fstart = '0; fend = PW'(DIGITS-1);
      start_from_ptr = 1'b0; end_from_ptr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    if (n >= 400) begin
      errors++; checks++;
      $display("FAIL %s watchdog: done missing, actual 0 expected 1", tag);
    end else begin
      check(int'(carry) == cy, {tag, " carry at done"}, carry, cy);
      check(busy == 1'b0, {tag, " R9 busy low with done"}, busy, 0);
      check(exq.size() == 0, {tag, " R2 writes outstanding"}, exq.size(), 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL global watchdog, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !carry && !wr_valid, "R1 outputs in reset",
          {busy, done, carry, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !carry && !wr_valid, "R1 outputs after reset",
          {busy, done, carry, wr_valid}, 0);

    for (int r = 0; r < NREG; r++) run(3, 0, r, 0, 13, 0, 0, 0, 0, "R5 clear");
    run(5, 0, 1, 0, 13, 0, 0, 0, 9, "R5 load");
    run(5, 0, 4, 0, 2,  0, 0, 0, 5, "R5 load");
    run(5, 0, 3, 0, 13, 0, 0, 0, 5, "R5 load");
    run(6, 1, 0, 0, 13, 0, 0, 0, 0, "R5 op6 as copy");
    run(1, 4, 3, 0, 3,  0, 0, 0, 0, "R6 add chain");
    run(1, 3, 1, 0, 13, 0, 0, 0, 0, "R6 add carry out");
    run(0, 3, 2, 2, 5,  0, 0, 0, 0, "R2 copy subfield");
    run(2, 1, 2, 0, 13, 0, 0, 0, 0, "R7 sub borrow out");
    run(2, 3, 3, 0, 13, 0, 0, 0, 0, "R7 sub self");
    run(5, 0, 6, 0, 13, 0, 0, 0, 3, "R5 load");
    run(2, 4, 6, 0, 5,  0, 0, 0, 0, "R7 sub chain");
    run(4, 1, 6, 4, 9,  0, 0, 0, 0, "R8 exchange");
    run(0, 1, 5, 9, 3,  0, 0, 0, 0, "R3 reversed field");
    run(5, 0, 5, 11, 15, 0, 0, 0, 8, "R3 clamp high");
    run(5, 0, 5, 15, 15, 0, 0, 0, 7, "R3 clamp both");
    run(5, 0, 7, 0, 8,  1, 0, 6, 4, "R4 ptr low bound");
    run(1, 1, 7, 0, 13, 0, 1, 2, 0, "R4 ptr high bound");
    run(0, 6, 2, 0, 13, 0, 0, 0, 0, "R9 start while busy", 1'b1);
    repeat (10) @(negedge clk);
    check(nwr == expwr, "R9 ignored start made no writes", nwr, expwr);
    run(0, 5, 0, 0, 13, 0, 0, 0, 0, "R9 reg5 untouched by ignored start");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule